// File: doc/BRIEF.md
# Unlock Command Decoder

This block sits behind the bus interface of a byte-wide nonvolatile memory. It turns chip-enable, write-strobe and output-enable activity into discrete write events, and it matches those events against two unlock grammars. The short grammar has three cycles: a key byte, a second key byte, then a command byte. The long grammar has six cycles: the same two keys, an extend byte, the two keys again, then a final command. A recognised command drives one-cycle pulses toward a page loader and an erase sequencer, or changes one of two mode flags that the block keeps. The first flag is a global software write-protect. The second is an identification mode, in which reads at the lowest addresses return a manufacturer code and a device code in place of array data.

A write that fits no sequence is handled in one of two ways. While protection is off, it becomes an ordinary byte load that opens a page. While protection is on, it is thrown away and the block turns busy for a fixed window. Once a page load is open, every write is page data until a quiet gap closes the page. The same gap rule also throws away a half-entered sequence.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: After reset, protectOn, idMode and busy are low and no pulse output is active. A reset taken at any point also clears protection and identification mode.
- R2: A bus write event needs ceN and weN both low while oeN is high. Its address is taken in the first cycle of that overlap and its data in the last cycle. With oeN low, no event occurs.
- R3: Matching compares only wrAddr[14:0]. The three-cycle form is AAh to 5555h, then 55h to 2AAAh, then a command byte to 5555h. Command 90h sets idMode and command F0h clears it. Neither produces a byte load.
- R4: Command A0h sets protectOn, pulses pageArm and opens a page load, whether protection was already on or not. The following writes pulse byteLoad with their own address and data, and protectOn stays high after the page closes.
- R5: Command byte 80h selects the six-cycle form: AAh to 5555h, then 55h to 2AAAh, then a final byte to 5555h. A final byte of 10h pulses eraseGo, 20h clears protectOn, and 60h sets idMode.
- R6: While idMode is high, a read with rdAddr[14:1] all zero raises idHit. idData is then BFh when rdAddr[0] is 0 and DEV_CODE when rdAddr[0] is 1. At any other address, idHit is low and idData is 00h.
- R7: While protectOn is high, a write that fits no sequence causes no pulse and raises busy for BUSY_CYCLES clock cycles. Every write that ends while busy is high is ignored.
- R8: A write that does not fit the next step of a sequence returns the decoder to idle. While protection is off, that write becomes a byte load carrying its own address and data, and it opens a page.
- R9: If GAP_CYCLES cycles pass with no new write, an open page closes with one pageCommit pulse, and a partly entered sequence is discarded.
- R10: A write that reaches the decoder in the same cycle the gap would expire keeps the page open and suppresses pageCommit for that cycle.
- R11: While a page load is open, every write is a byte load, including writes that would otherwise match a key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bus pins are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output enable, active low; low inhibits writes |
| wrAddr | input | ADDR_W | Bus address of the write |
| wrData | input | 8 | Bus data of the write |
| rdAddr | input | 15 | Read address used by identification mode |
| idHit | output | 1 | The read targets an identification code |
| idData | output | 8 | Identification code for the read |
| pageArm | output | 1 | Pulse: protected page write accepted |
| byteLoad | output | 1 | Pulse: one byte goes to the page buffer |
| loadAddr | output | ADDR_W | Address for byteLoad |
| loadData | output | 8 | Data for byteLoad |
| pageCommit | output | 1 | Pulse: page load closed, start the array write |
| eraseGo | output | 1 | Pulse: chip erase requested |
| protectOn | output | 1 | Global write-protect flag |
| idMode | output | 1 | Identification mode flag |
| busy | output | 1 | Blocked-write window is active |

## Verification
Gap expiry and the arrival of a new byte can fall on the same clock edge. The page-commit logic and the byte-load logic both want that edge. The bench places the second write of a page at three distances from the first: one cycle early, exactly on the expiry edge, and one cycle late. It works out each distance from the register stages between the bus pins and the decoder. On the expiry edge and on the early edge, no pageCommit may appear until the later quiet period. On the late edge, one commit must appear before the second byte starts a new page.

// File: rtl/ucd_pkg.sv
package ucd_pkg;

  localparam int CMP_W = 15;

  localparam logic [CMP_W-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [CMP_W-1:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [7:0] KEY_DATA_A = 8'hAA;
  localparam logic [7:0] KEY_DATA_B = 8'h55;

  localparam logic [7:0] OP_PAGE    = 8'hA0;
  localparam logic [7:0] OP_ID_IN   = 8'h90;
  localparam logic [7:0] OP_ID_OUT  = 8'hF0;
  localparam logic [7:0] OP_EXTEND  = 8'h80;
  localparam logic [7:0] OP_ERASE   = 8'h10;
  localparam logic [7:0] OP_UNLOCK  = 8'h20;
  localparam logic [7:0] OP_ID_ALT  = 8'h60;
  localparam logic [7:0] MAKER_CODE = 8'hBF;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_KEY1,
    SQ_KEY2,
    SQ_EXT1,
    SQ_EXT2,
    SQ_EXT3
  } seqState_t;

  typedef struct packed {
    logic takeLoad;
    logic idEnable;
  } dpStrobe_t;

endpackage

// File: rtl/ucd_datapath.sv
module ucd_datapath
  import ucd_pkg::*;
#(
  parameter int          ADDR_W   = 18,
  parameter logic [7:0]  DEV_CODE = 8'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [CMP_W-1:0]  rdAddr,
  input  dpStrobe_t         strobe,
  output logic              cycValid,
  output logic [ADDR_W-1:0] cycAddr,
  output logic [7:0]        cycData,
  output logic [ADDR_W-1:0] loadAddr,
  output logic [7:0]        loadData,
  output logic              idHit,
  output logic [7:0]        idData
);

  logic busActive;
  logic prevActive;

  // A write cycle is the overlap of both strobes low, with output drive off.
  assign busActive = !ceN && !weN && oeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevActive <= 1'b0;
      cycValid   <= 1'b0;
      cycAddr    <= '0;
      cycData    <= '0;
    end else begin
      prevActive <= busActive;
      cycValid   <= prevActive && !busActive;
      if (busActive && !prevActive) cycAddr <= wrAddr;
      if (busActive)                cycData <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadAddr <= '0;
      loadData <= '0;
    end else if (strobe.takeLoad) begin
      loadAddr <= cycAddr;
      loadData <= cycData;
    end
  end

  logic lowWindow;
  assign lowWindow = (rdAddr[CMP_W-1:1] == '0);

  always_comb begin
    idHit  = strobe.idEnable && lowWindow;
    idData = 8'h00;
    if (idHit) idData = rdAddr[0] ? DEV_CODE : MAKER_CODE;
  end

endmodule

// File: rtl/ucd_control.sv
module ucd_control
  import ucd_pkg::*;
#(
  parameter int GAP_CYCLES  = 32,
  parameter int BUSY_CYCLES = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycValid,
  input  logic [CMP_W-1:0] cmpAddr,
  input  logic [7:0]       cycData,
  output dpStrobe_t        strobe,
  output logic             pageArm,
  output logic             byteLoad,
  output logic             pageCommit,
  output logic             eraseGo,
  output logic             protectOn,
  output logic             idMode,
  output logic             busy
);

  localparam int GAP_W  = (GAP_CYCLES > 2) ? $clog2(GAP_CYCLES) : 1;
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [GAP_W-1:0]  GAP_LAST  = GAP_W'(GAP_CYCLES - 1);
  localparam logic [BUSY_W-1:0] BUSY_LOAD = BUSY_W'(BUSY_CYCLES);

  seqState_t state, stateNx;
  logic [GAP_W-1:0]  gapCnt, gapNx;
  logic [BUSY_W-1:0] busyCnt;
  logic loadOpen, openNx;
  logic protNx, idNx;
  logic armNx, loadNx, commitNx, eraseNx, blockNx;
  logic stray, take, atA, atB;

  assign busy = (busyCnt != '0);
  assign take = cycValid && !busy;
  assign atA  = (cmpAddr == KEY_ADDR_A);
  assign atB  = (cmpAddr == KEY_ADDR_B);

  always_comb begin
    stateNx  = state;
    gapNx    = gapCnt;
    openNx   = loadOpen;
    protNx   = protectOn;
    idNx     = idMode;
    armNx    = 1'b0;
    loadNx   = 1'b0;
    commitNx = 1'b0;
    eraseNx  = 1'b0;
    blockNx  = 1'b0;
    stray    = 1'b0;
    if (take) begin
      gapNx = '0;
      if (loadOpen) begin
        loadNx = 1'b1;
      end else begin
        unique case (state)
          SQ_IDLE: if (atA && cycData == KEY_DATA_A) stateNx = SQ_KEY1; else stray = 1'b1;
          SQ_KEY1: if (atB && cycData == KEY_DATA_B) stateNx = SQ_KEY2; else stray = 1'b1;
          SQ_KEY2: begin
            stateNx = SQ_IDLE;
            if (!atA) stray = 1'b1;
            else begin
              unique case (cycData)
                OP_PAGE: begin
                  protNx = 1'b1;
                  openNx = 1'b1;
                  armNx  = 1'b1;
                end
                OP_ID_IN:  idNx    = 1'b1;
                OP_ID_OUT: idNx    = 1'b0;
                OP_EXTEND: stateNx = SQ_EXT1;
                default:   stray   = 1'b1;
              endcase
            end
          end
          SQ_EXT1: if (atA && cycData == KEY_DATA_A) stateNx = SQ_EXT2; else stray = 1'b1;
          SQ_EXT2: if (atB && cycData == KEY_DATA_B) stateNx = SQ_EXT3; else stray = 1'b1;
          SQ_EXT3: begin
            stateNx = SQ_IDLE;
            if (!atA) stray = 1'b1;
            else begin
              unique case (cycData)
                OP_ERASE:  eraseNx = 1'b1;
                OP_UNLOCK: protNx  = 1'b0;
                OP_ID_ALT: idNx    = 1'b1;
                default:   stray   = 1'b1;
              endcase
            end
          end
          default: stray = 1'b1;
        endcase
        if (stray) begin
          stateNx = SQ_IDLE;
          if (protectOn) blockNx = 1'b1;
          else begin
            loadNx = 1'b1;
            openNx = 1'b1;
          end
        end
      end
    end else if (!cycValid && (loadOpen || state != SQ_IDLE)) begin
      if (gapCnt == GAP_LAST) begin
        gapNx   = '0;
        stateNx = SQ_IDLE;
        if (loadOpen) begin
          commitNx = 1'b1;
          openNx   = 1'b0;
        end
      end else begin
        gapNx = gapCnt + GAP_W'(1);
      end
    end
  end

  always_comb begin
    strobe.takeLoad = loadNx;
    strobe.idEnable = idMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= SQ_IDLE;
      gapCnt     <= '0;
      busyCnt    <= '0;
      loadOpen   <= 1'b0;
      protectOn  <= 1'b0;
      idMode     <= 1'b0;
      pageArm    <= 1'b0;
      byteLoad   <= 1'b0;
      pageCommit <= 1'b0;
      eraseGo    <= 1'b0;
    end else begin
      state      <= stateNx;
      gapCnt     <= gapNx;
      loadOpen   <= openNx;
      protectOn  <= protNx;
      idMode     <= idNx;
      pageArm    <= armNx;
      byteLoad   <= loadNx;
      pageCommit <= commitNx;
      eraseGo    <= eraseNx;
      if (blockNx)      busyCnt <= BUSY_LOAD;
      else if (busy)    busyCnt <= busyCnt - BUSY_W'(1);
    end
  end

endmodule

// File: rtl/unlock_cmd_decoder.sv
module unlock_cmd_decoder
  import ucd_pkg::*;
#(
  parameter int         ADDR_W      = 18,
  parameter logic [7:0] DEV_CODE    = 8'h10,
  parameter int         GAP_CYCLES  = 32,
  parameter int         BUSY_CYCLES = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [14:0]       rdAddr,
  output logic              idHit,
  output logic [7:0]        idData,
  output logic              pageArm,
  output logic              byteLoad,
  output logic [ADDR_W-1:0] loadAddr,
  output logic [7:0]        loadData,
  output logic              pageCommit,
  output logic              eraseGo,
  output logic              protectOn,
  output logic              idMode,
  output logic              busy
);

  dpStrobe_t         strobe;
  logic              cycValid;
  logic [ADDR_W-1:0] cycAddr;
  logic [7:0]        cycData;

  ucd_datapath #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .strobe(strobe),
    .cycValid(cycValid), .cycAddr(cycAddr), .cycData(cycData),
    .loadAddr(loadAddr), .loadData(loadData), .idHit(idHit), .idData(idData)
  );

  ucd_control #(.GAP_CYCLES(GAP_CYCLES), .BUSY_CYCLES(BUSY_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN), .cycValid(cycValid),
    .cmpAddr(cycAddr[CMP_W-1:0]), .cycData(cycData), .strobe(strobe),
    .pageArm(pageArm), .byteLoad(byteLoad), .pageCommit(pageCommit),
    .eraseGo(eraseGo), .protectOn(protectOn), .idMode(idMode), .busy(busy)
  );

endmodule

// File: rtl/ucd_checker.sv
module ucd_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cycValid,
  input logic        busy,
  input logic        pageArm,
  input logic        byteLoad,
  input logic        pageCommit,
  input logic        eraseGo,
  input logic        protectOn,
  input logic        idMode,
  input logic [14:0] rdAddr,
  input logic [7:0]  idData
);

  // R7: nothing is decoded during the blocked-write window
  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!byteLoad && !pageArm && !eraseGo));

  // R4: an accepted protected page write leaves protection set
  a_r4_arm_protects: assert property (@(posedge clk) disable iff (!rstN)
    pageArm |-> protectOn);

  // R6: manufacturer code at the lowest identification address
  a_r6_maker_code: assert property (@(posedge clk) disable iff (!rstN)
    (idMode && rdAddr == 15'h0000) |-> (idData == 8'hBF));

  // R10: commit and load never share a cycle, nor do any two command pulses
  a_r10_one_event: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pageArm, byteLoad, pageCommit, eraseGo}));

  // R2: mode flags move only after a captured bus write
  a_r2_flags_need_cycle: assert property (@(posedge clk) disable iff (!rstN)
    !cycValid |=> ($stable(protectOn) && $stable(idMode)));

endmodule

bind unlock_cmd_decoder ucd_checker u_chk (
  .clk(clk), .rstN(rstN), .cycValid(cycValid), .busy(busy),
  .pageArm(pageArm), .byteLoad(byteLoad), .pageCommit(pageCommit),
  .eraseGo(eraseGo), .protectOn(protectOn), .idMode(idMode),
  .rdAddr(rdAddr), .idData(idData)
);

// File: tb/sim_unlock_cmd_decoder.sv
module sim_unlock_cmd_decoder;

  localparam int GAP  = 32;
  localparam int BUSY = 24;
  localparam logic [7:0] DEV = 8'h10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [17:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [14:0] rdAddr = '0;
  logic idHit, pageArm, byteLoad, pageCommit, eraseGo, protectOn, idMode, busy;
  logic [7:0]  idData, loadData;
  logic [17:0] loadAddr;

  int errs = 0, checks = 0;
  int armCnt = 0, loadCnt = 0, commitCnt = 0, eraseCnt = 0;
  logic [17:0] lastAddr = '0;
  logic [7:0]  lastData = '0;

  always #10 clk = ~clk;

  unlock_cmd_decoder #(.ADDR_W(18), .DEV_CODE(DEV), .GAP_CYCLES(GAP), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .idHit(idHit), .idData(idData), .pageArm(pageArm), .byteLoad(byteLoad),
    .loadAddr(loadAddr), .loadData(loadData), .pageCommit(pageCommit),
    .eraseGo(eraseGo), .protectOn(protectOn), .idMode(idMode), .busy(busy)
  );

  always @(posedge clk) begin
    if (pageArm)    armCnt++;
    if (pageCommit) commitCnt++;
    if (eraseGo)    eraseCnt++;
    if (byteLoad) begin
      loadCnt++;
      lastAddr = loadAddr;
      lastData = loadData;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Address held only in the first overlap cycle, data valid only in the last.
  task automatic busCycle(input logic [17:0] a, input logic [7:0] d);
    @(negedge clk);
    wrAddr = a; wrData = ~d; ceN = 1'b0; weN = 1'b0;
    @(negedge clk);
    wrAddr = a ^ 18'h07FFF; wrData = d;
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
  endtask

  task automatic wr(input logic [17:0] a, input logic [7:0] d);
    busCycle(a, d);
    repeat (4) @(negedge clk);
  endtask

  task automatic seq3(input logic [7:0] op);
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, op);
  endtask

  task automatic seq6(input logic [7:0] op);
    seq3(8'h80);
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, op);
  endtask

  task automatic quiet();
    repeat (GAP + 6) @(negedge clk);
  endtask

  typedef struct packed {
    logic [15:0] a;
    logic [7:0]  d;
    logic        p;
    logic        i;
    logic        e;
  } vec_t;

  localparam vec_t VEC [0:20] = '{
    '{16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0},
    '{16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0},
    '{16'h5555, 8'h90, 1'b0, 1'b1, 1'b0},
    '{16'hD555, 8'hAA, 1'b0, 1'b1, 1'b0},
    '{16'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0},
    '{16'h5555, 8'hF0, 1'b0, 1'b0, 1'b0},
    '{16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0},
    '{16'hAAAA, 8'h55, 1'b0, 1'b0, 1'b0},
    '{16'h5555, 8'h80, 1'b0, 1'b0, 1'b0},
    '{16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0},
    '{16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0},
    '{16'hD555, 8'h60, 1'b0, 1'b1, 1'b0},
    '{16'h5555, 8'hAA, 1'b0, 1'b1, 1'b0},
    '{16'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0},
    '{16'h5555, 8'hF0, 1'b0, 1'b0, 1'b0},
    '{16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0},
    '{16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0},
    '{16'h5555, 8'h80, 1'b0, 1'b0, 1'b0},
    '{16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0},
    '{16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0},
    '{16'h5555, 8'h10, 1'b0, 1'b0, 1'b1}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    int base, c0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!protectOn && !idMode && !busy, "R1 reset flags", {protectOn, idMode, busy}, 0);
    check(!pageArm && !byteLoad && !pageCommit && !eraseGo, "R1 reset pulses",
          {pageArm, byteLoad, pageCommit, eraseGo}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Table: R3 three-cycle forms, R5 six-cycle forms, bit 15 ignored
    for (int k = 0; k <= 20; k++) begin
      wr({2'b00, VEC[k].a}, VEC[k].d);
      check(protectOn == VEC[k].p && idMode == VEC[k].i && eraseCnt == int'(VEC[k].e),
            $sformatf("R3 R5 table step %0d", k), {protectOn, idMode, eraseCnt[0]},
            {VEC[k].p, VEC[k].i, VEC[k].e});
    end
    check(loadCnt == 0 && armCnt == 0, "R3 commands load nothing", loadCnt, 0);

    // R6 identification reads
    seq3(8'h90);
    rdAddr = 15'h0000; #1;
    check(idHit && idData == 8'hBF, "R6 maker code", idData, 8'hBF);
    rdAddr = 15'h0001; #1;
    check(idHit && idData == DEV, "R6 device code", idData, DEV);
    rdAddr = 15'h0002; #1;
    check(!idHit && idData == 8'h00, "R6 outside window", {idHit, idData}, 0);
    seq3(8'hF0);
    rdAddr = 15'h0000; #1;
    check(!idHit && !idMode, "R6 exit clears mode", {idHit, idMode}, 0);

    // R2 output enable low inhibits writes
    base = loadCnt;
    oeN = 1'b0;
    wr(18'h00123, 8'h5A);
    oeN = 1'b1;
    check(loadCnt == base, "R2 oeN low inhibits", loadCnt, base);
    // R2 address from first cycle, data from last; R8 stray write loads
    wr(18'h00123, 8'h5A);
    check(loadCnt == base + 1 && lastAddr == 18'h00123 && lastData == 8'h5A,
          "R2 capture", {lastAddr, lastData}, {18'h00123, 8'h5A});
    // R11 key byte inside open page is data
    wr(18'h05555, 8'hAA);
    check(loadCnt == base + 2 && lastData == 8'hAA, "R11 key as data", lastData, 8'hAA);
    c0 = commitCnt;
    quiet();
    check(commitCnt == c0 + 1, "R9 page closes", commitCnt, c0 + 1);

    // R8 abort mid-sequence becomes a byte load
    base = loadCnt;
    wr(18'h05555, 8'hAA);
    wr(18'h01111, 8'h22);
    check(loadCnt == base + 1 && lastAddr == 18'h01111 && lastData == 8'h22,
          "R8 abort load", {lastAddr, lastData}, {18'h01111, 8'h22});
    quiet();

    // R9 partial sequence discarded after gap
    base = loadCnt;
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55);
    quiet();
    wr(18'h05555, 8'h90);
    check(!idMode && loadCnt == base + 1, "R9 partial dropped", {idMode, loadCnt[7:0]}, base + 1);
    quiet();

    // R10 second byte on the expiry edge, early, and late
    c0 = commitCnt;
    busCycle(18'h00300, 8'h01);
    repeat (GAP - 3) @(negedge clk);
    busCycle(18'h00301, 8'h02);
    repeat (4) @(negedge clk);
    check(commitCnt == c0, "R10 arrival on expiry edge", commitCnt, c0);
    busCycle(18'h00302, 8'h03);
    repeat (GAP - 4) @(negedge clk);
    busCycle(18'h00303, 8'h04);
    repeat (4) @(negedge clk);
    check(commitCnt == c0, "R10 early arrival", commitCnt, c0);
    quiet();
    check(commitCnt == c0 + 1, "R10 single commit", commitCnt, c0 + 1);
    busCycle(18'h00304, 8'h05);
    repeat (GAP - 2) @(negedge clk);
    busCycle(18'h00305, 8'h06);
    repeat (4) @(negedge clk);
    check(commitCnt == c0 + 2, "R10 late arrival commits", commitCnt, c0 + 2);
    quiet();

    // R4 protected page write
    base = loadCnt;
    seq3(8'hA0);
    check(protectOn && armCnt == 1 && loadCnt == base, "R4 arm", {protectOn, armCnt[3:0]}, 5'h11);
    wr(18'h00456, 8'h77);
    check(loadCnt == base + 1 && lastAddr == 18'h00456 && lastData == 8'h77,
          "R4 page byte", {lastAddr, lastData}, {18'h00456, 8'h77});
    quiet();
    check(protectOn, "R4 stays protected", protectOn, 1);

    // R7 blocked write and busy window
    base = loadCnt;
    wr(18'h00100, 8'h11);
    check(busy && loadCnt == base, "R7 blocked write", {busy, loadCnt[7:0]}, {1'b1, base[7:0]});
    busCycle(18'h05555, 8'hAA); busCycle(18'h02AAA, 8'h55); busCycle(18'h05555, 8'h90);
    @(negedge clk);
    check(busy && !idMode, "R7 ignored while busy", {busy, idMode}, 2'b10);
    repeat (BUSY + 4) @(negedge clk);
    check(!busy && !idMode && loadCnt == base, "R7 window ends", {busy, idMode}, 0);

    // R4 bypass while already protected
    seq3(8'hA0);
    wr(18'h00457, 8'h66);
    check(armCnt == 2 && lastData == 8'h66 && loadCnt == base + 1, "R4 bypass", lastData, 8'h66);
    quiet();
    check(protectOn, "R4 protection kept", protectOn, 1);

    // R5 disable protection, then plain write loads
    seq6(8'h20);
    check(!protectOn, "R5 disable", protectOn, 0);
    wr(18'h00500, 8'h99);
    check(loadCnt == base + 2 && lastData == 8'h99, "R5 unprotected load", lastData, 8'h99);
    quiet();

    // R1 reset clears modes at any time
    seq3(8'h90);
    seq3(8'hA0);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(!protectOn && !idMode && !busy, "R1 reset clears", {protectOn, idMode}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule